// File: doc/BRIEF.md
# Dual-Die Serial Flash Command Router

This block lets two identical 512 Mbit serial NOR dies share a single chip select and appear to the host as one 1 Gbit device. It runs on a free-running system clock. It receives the serial stream as a data bit `sdi` plus a one-cycle strobe `sck_en` for each rising serial clock edge. It decodes the opcode and, where the opcode carries one, the address. From these it decides which die the transaction goes to.

Opcodes that act on the whole device without an address are sent to both dies at once. Legacy register opcodes that carry no address cannot name a die, so the block refuses them and raises an error flag. Every other opcode is treated as addressed. In 4-byte mode, one address bit picks the die, and the die sees the address with that bit removed. The block holds the device-wide 4-byte address mode flag.

For the plain read opcode, the data phase is modelled as a byte address counter. This counter wraps inside the selected die and never moves to the other die.

Top module: `dual_die_spi_router`

## Requirements
- R1: After reset, `lo_en`, `hi_en`, `err` and `addr4_mode` are 0.
- R2: Opcodes 06h, 04h, 82h, 30h, 99h and B7h raise both `lo_en` and `hi_en` once their eighth bit is sampled. No address follows them, `err` stays 0, and `fwd_op` shows the opcode.
- R3: Opcode B7h sets `addr4_mode` to 1. Opcode 99h clears it to 0. The flag keeps its value across frames.
- R4: Opcodes 01h, 35h, 05h and 07h enable neither die. `err` goes to 1 after their eighth bit and returns to 0 once chip select is high.
- R5: When `addr4_mode` is 1, any other opcode is followed by a 32-bit address sent MSB first. Bit 26 set to 0 enables only `lo_en`, and set to 1 enables only `hi_en`. `die_addr` takes bits 25:0, and bits 31:27 have no effect.
- R6: When `addr4_mode` is 0, an addressed opcode takes a 24-bit address. The lower die is always the target, and `die_addr` is that address zero-extended.
- R7: No die enable rises before the last address bit is sampled. If chip select rises before that bit, or in the same cycle as its strobe, no die is enabled in that frame.
- R8: `lo_en` and `hi_en` fall in the same cycle that `cs_n` goes high, with no clock edge needed.
- R9: For read opcode 03h, `die_addr` advances by one after every 8 data bits. It goes from 0x3FF_FFFF to 0x000_0000, and the selected die does not change.
- R10: For addressed opcodes other than 03h, `die_addr` stays constant for the rest of the frame, whatever bits follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Shared chip select, active low |
| sck_en | input | 1 | One-cycle strobe marking a serial clock rising edge |
| sdi | input | 1 | Serial data bit, sampled with `sck_en` |
| lo_en | output | 1 | Lower die enable |
| hi_en | output | 1 | Upper die enable |
| die_addr | output | 26 | Address presented to the enabled die |
| fwd_op | output | 8 | Opcode forwarded to the enabled dies |
| err | output | 1 | Unsupported opcode in the current frame |
| addr4_mode | output | 1 | 4-byte address mode flag |

## Verification
Chip select rising and the final address bit strobe can arrive in the same clock cycle. In that case the frame must abort instead of latching a die selection. The bench drives `cs_n` high in the very cycle that carries the strobe for the 32nd address bit. It then lowers chip select again and checks that neither die enable appears. A second collision occurs on the last byte of a half, where the byte increment and the wrap to zero land on the same edge. This is judged by `die_addr` returning to 0 while the same die enable stays high.

// File: rtl/dual_die_spi_router.sv
module dual_die_spi_router #(
  parameter int         DIE_AW = 26,
  parameter logic [7:0] RD_OP  = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_en,
  input  logic              sdi,
  output logic              lo_en,
  output logic              hi_en,
  output logic [DIE_AW-1:0] die_addr,
  output logic [7:0]        fwd_op,
  output logic              err,
  output logic              addr4_mode
);
  localparam int LONG_BITS  = 32;
  localparam int SHORT_BITS = 24;
  localparam int CW         = $clog2(LONG_BITS);
  localparam logic [7:0] OP_4B  = 8'hB7;
  localparam logic [7:0] OP_RST = 8'h99;

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DAT, PH_HOLD} ph_t;

  ph_t                  ph;
  logic [CW-1:0]        cnt;
  logic [2:0]           bcnt;
  logic [LONG_BITS-1:0] sh;
  logic [1:0]           sel;

  logic [LONG_BITS-1:0] sh_nx;
  logic [7:0]           op_nx;
  logic                 is_bcast, is_legacy, die_hi;
  logic [CW-1:0]        alast;
  logic [DIE_AW-1:0]    adr_nx;

  assign sh_nx     = {sh[LONG_BITS-2:0], sdi};
  assign op_nx     = sh_nx[7:0];
  assign is_bcast  = op_nx inside {8'hB7, 8'h82, 8'h30, 8'h99, 8'h06, 8'h04};
  assign is_legacy = op_nx inside {8'h01, 8'h35, 8'h05, 8'h07};
  assign alast     = addr4_mode ? CW'(LONG_BITS - 1) : CW'(SHORT_BITS - 1);
  assign die_hi    = addr4_mode & sh_nx[DIE_AW];
  assign adr_nx    = addr4_mode ? sh_nx[DIE_AW-1:0] : DIE_AW'(sh_nx[SHORT_BITS-1:0]);

  assign lo_en = sel[0] & ~cs_n;
  assign hi_en = sel[1] & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_OPC;
      cnt        <= '0;
      bcnt       <= '0;
      sh         <= '0;
      sel        <= '0;
      err        <= 1'b0;
      addr4_mode <= 1'b0;
      fwd_op     <= '0;
      die_addr   <= '0;
    end else if (cs_n) begin
      ph   <= PH_OPC;
      cnt  <= '0;
      bcnt <= '0;
      sel  <= '0;
      err  <= 1'b0;
    end else if (sck_en) begin
      sh <= sh_nx;
      unique case (ph)
        PH_OPC: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(7)) begin
            cnt    <= '0;
            fwd_op <= op_nx;
            if (is_bcast) begin
              sel <= 2'b11;
              ph  <= PH_HOLD;
              if (op_nx == OP_4B)       addr4_mode <= 1'b1;
              else if (op_nx == OP_RST) addr4_mode <= 1'b0;
            end else if (is_legacy) begin
              err <= 1'b1;
              ph  <= PH_HOLD;
            end else begin
              ph <= PH_ADR;
            end
          end
        end
        PH_ADR: begin
          cnt <= cnt + CW'(1);
          if (cnt == alast) begin
            die_addr <= adr_nx;
            sel      <= die_hi ? 2'b10 : 2'b01;
            bcnt     <= '0;
            ph       <= (fwd_op == RD_OP) ? PH_DAT : PH_HOLD;
          end
        end
        PH_DAT: begin
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) die_addr <= die_addr + DIE_AW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_die_spi_router_chk.sv
module dual_die_spi_router_chk #(
  parameter int DIE_AW = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              lo_en,
  input logic              hi_en,
  input logic [DIE_AW-1:0] die_addr,
  input logic [7:0]        fwd_op,
  input logic              err,
  input logic              addr4_mode
);
  p_pair_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_en && hi_en) |-> (fwd_op inside {8'hB7, 8'h82, 8'h30, 8'h99, 8'h06, 8'h04}));

  p_mode_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr4_mode) |-> fwd_op == 8'hB7);

  p_mode_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr4_mode) |-> fwd_op == 8'h99);

  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!lo_en && !hi_en && (fwd_op inside {8'h01, 8'h35, 8'h05, 8'h07})));

  p_lo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && $past(lo_en) && !$past(hi_en)) |-> (lo_en && !hi_en));

  p_hi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && $past(hi_en) && !$past(lo_en)) |-> (hi_en && !lo_en));

  p_cs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!lo_en && !hi_en));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_en ^ hi_en) && $past(lo_en ^ hi_en) && !$stable(die_addr))
      |-> die_addr == $past(die_addr) + DIE_AW'(1));
endmodule

bind dual_die_spi_router dual_die_spi_router_chk #(.DIE_AW(DIE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .lo_en(lo_en), .hi_en(hi_en),
  .die_addr(die_addr), .fwd_op(fwd_op), .err(err), .addr4_mode(addr4_mode)
);

// File: tb/dual_die_spi_router_tb_top.sv
module dual_die_spi_router_tb_top;
  localparam int AW = 26;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck_en = 1'b0;
  logic sdi = 1'b0;
  logic lo_en, hi_en, err, addr4_mode;
  logic [AW-1:0] die_addr;
  logic [7:0] fwd_op;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_die_spi_router dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_en(sck_en), .sdi(sdi),
    .lo_en(lo_en), .hi_en(hi_en), .die_addr(die_addr), .fwd_op(fwd_op),
    .err(err), .addr4_mode(addr4_mode)
  );

  // {mode before, opcode, address, exp lo, exp hi, exp err, exp die address}
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 8'h03, 32'h0000_0010, 1'b1, 1'b0, 1'b0, 26'h000_0010},
    {1'b1, 8'h03, 32'h0400_0020, 1'b0, 1'b1, 1'b0, 26'h000_0020},
    {1'b1, 8'h65, 32'h0080_0002, 1'b1, 1'b0, 1'b0, 26'h080_0002},
    {1'b1, 8'h71, 32'h0480_0003, 1'b0, 1'b1, 1'b0, 26'h080_0003},
    {1'b1, 8'h02, 32'hF800_0100, 1'b1, 1'b0, 1'b0, 26'h000_0100},
    {1'b1, 8'h02, 32'hFC00_0100, 1'b0, 1'b1, 1'b0, 26'h000_0100},
    {1'b0, 8'h03, 32'h00AB_CDEF, 1'b1, 1'b0, 1'b0, 26'h0AB_CDEF},
    {1'b0, 8'h65, 32'h00FF_FFFF, 1'b1, 1'b0, 1'b0, 26'h0FF_FFFF},
    {1'b0, 8'h06, 32'h0,         1'b1, 1'b1, 1'b0, 26'h0},
    {1'b1, 8'h04, 32'h0,         1'b1, 1'b1, 1'b0, 26'h0},
    {1'b0, 8'h82, 32'h0,         1'b1, 1'b1, 1'b0, 26'h0},
    {1'b1, 8'h30, 32'h0,         1'b1, 1'b1, 1'b0, 26'h0},
    {1'b0, 8'hB7, 32'h0,         1'b1, 1'b1, 1'b0, 26'h0},
    {1'b1, 8'h99, 32'h0,         1'b1, 1'b1, 1'b0, 26'h0},
    {1'b1, 8'h01, 32'h0,         1'b0, 1'b0, 1'b1, 26'h0},
    {1'b0, 8'h35, 32'h0,         1'b0, 1'b0, 1'b1, 26'h0},
    {1'b1, 8'h05, 32'h0,         1'b0, 1'b0, 1'b1, 26'h0},
    {1'b0, 8'h07, 32'h0,         1'b0, 1'b0, 1'b1, 26'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdi = v[i];
      sck_en = 1'b1;
      @(negedge clk);
      sck_en = 1'b0;
    end
  endtask

  task automatic cs_on;
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic cs_off;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic m4);
    cs_on();
    send_bits(m4 ? 32'hB7 : 32'h99, 8);
    cs_off();
  endtask

  function automatic logic is_bc(input logic [7:0] op);
    return op inside {8'hB7, 8'h82, 8'h30, 8'h99, 8'h06, 8'h04};
  endfunction

  function automatic logic is_lg(input logic [7:0] op);
    return op inside {8'h01, 8'h35, 8'h05, 8'h07};
  endfunction

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  logic [69:0] cur;
  logic        m4;
  logic [7:0]  op;
  string       tag;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lo_en", lo_en, 0);
    chk("R1 hi_en", hi_en, 0);
    chk("R1 err", err, 0);
    chk("R1 addr4_mode", addr4_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      cur = VEC[k];
      m4 = cur[69];
      op = cur[68:61];
      tag = is_bc(op) ? "R2" : is_lg(op) ? "R4" : m4 ? "R5" : "R6";
      set_mode(m4);
      cs_on();
      send_bits({24'h0, op}, 8);
      if (!is_bc(op) && !is_lg(op)) send_bits(cur[60:29], m4 ? 32 : 24);
      chk({tag, " lo_en"}, lo_en, cur[28]);
      chk({tag, " hi_en"}, hi_en, cur[27]);
      chk({tag, " err"}, err, cur[26]);
      if (cur[28] ^ cur[27]) chk({tag, " die_addr"}, die_addr, cur[25:0]);
      if (cur[28] || cur[27]) chk({tag, " fwd_op"}, fwd_op, op);
      if (op == 8'hB7) chk("R3 set", addr4_mode, 1);
      if (op == 8'h99) chk("R3 clear", addr4_mode, 0);
      @(negedge clk);
      cs_n = 1'b1;
      #1;
      chk("R8 lo_en", lo_en, 0);
      chk("R8 hi_en", hi_en, 0);
      @(negedge clk);
      chk("R4 err cleared", err, 0);
    end

    // R3: flag persists across an unrelated frame
    set_mode(1'b1);
    cs_on();
    send_bits(32'h06, 8);
    cs_off();
    chk("R3 persist", addr4_mode, 1);

    // R7: enables stay low before the last address bit, and a short frame aborts
    cs_on();
    send_bits(32'h03, 8);
    send_bits(32'h0400_0000 >> 1, 31);
    chk("R7 lo before last bit", lo_en, 0);
    chk("R7 hi before last bit", hi_en, 0);
    cs_off();
    cs_on();
    #1;
    chk("R7 no carry-over", lo_en | hi_en, 0);
    cs_off();

    // R7: chip select rises in the same cycle as the last address bit strobe
    cs_on();
    send_bits(32'h03, 8);
    send_bits(32'h0400_0001 >> 1, 31);
    @(negedge clk);
    sdi = 1'b1;
    sck_en = 1'b1;
    cs_n = 1'b1;
    @(negedge clk);
    sck_en = 1'b0;
    chk("R7 collision while high", lo_en | hi_en, 0);
    cs_n = 1'b0;
    #1;
    chk("R7 collision after reopen", lo_en | hi_en, 0);
    cs_off();

    // R9: wrap at the end of the lower half
    cs_on();
    send_bits(32'h03, 8);
    send_bits(32'h03FF_FFFE, 32);
    chk("R9 lower start", die_addr, 26'h3FF_FFFE);
    send_bits(32'h0, 7);
    chk("R9 partial byte", die_addr, 26'h3FF_FFFE);
    send_bits(32'h0, 1);
    chk("R9 lower step", die_addr, 26'h3FF_FFFF);
    send_bits(32'h0, 8);
    chk("R9 lower wrap", die_addr, 26'h000_0000);
    chk("R9 lower die kept", {lo_en, hi_en}, 2'b10);
    cs_off();

    // R9: wrap at the end of the upper half
    cs_on();
    send_bits(32'h03, 8);
    send_bits(32'h07FF_FFFF, 32);
    chk("R9 upper start", die_addr, 26'h3FF_FFFF);
    send_bits(32'h0, 8);
    chk("R9 upper wrap", die_addr, 26'h000_0000);
    chk("R9 upper die kept", {lo_en, hi_en}, 2'b01);
    cs_off();

    // R10: register read keeps its address during trailing bits
    cs_on();
    send_bits(32'h65, 8);
    send_bits(32'h0400_0005, 32);
    send_bits(32'hFFFF, 16);
    chk("R10 address held", die_addr, 26'h000_0005);
    chk("R10 die", {lo_en, hi_en}, 2'b01);
    cs_off();

    finish_run();
  end
endmodule